// File: doc/BRIEF.md
# Pulse-Width Window Watchdog Evaluator

This block supervises a controller by timing the trigger pulses it emits. It counts watchdog-clock cycles while the synchronized trigger is high and compares that width with a window set by parameters. A pulse inside the window is good and one outside it is bad. A two-bit saturating score moves up on good pulses and down on bad ones. When the score climbs to three, an OK latch is set. When the score falls to zero, the latch is cleared. At scores one and two the latch keeps its value. With the score and the latch together there are six reachable states.

While OK is set, the window moves one clock later. This hysteresis keeps a pulse that sits right at a bound from flipping the decision back and forth. Two things drive the score straight to zero and drop OK: a period with no rising trigger edge, and an oscillator-error input. The enable output repeats the OK flag, so the supervised system can be gated on it.

Top module: `pulse_window_wd`

## Requirements
- R1: The width of a pulse is the number of consecutive watchdog clocks in which the synchronized trigger is sampled high. With OK clear, the pulse is good when LO_BOUND <= width <= HI_BOUND and bad otherwise. The decision is made when the pulse ends.
- R2: Each good pulse raises the score by 1, up to a maximum of 3. Each bad pulse lowers it by 1, down to a minimum of 0.
- R3: `wdOk` (1 = OK) becomes 1 when the score reaches 3 and becomes 0 when the score reaches 0. At scores 1 and 2 it keeps its previous value.
- R4: While `rstN` is low and after it is released, the score is 0 and `wdOk` and `enableOut` are 0.
- R5: If MISS_LIMIT watchdog clocks pass with no rising trigger edge, the score is forced to 0 and `wdOk` is cleared. This timeout takes priority over a pulse decision in the same cycle. Gaps shorter than the limit have no effect.
- R6: While `oscErr` is 1, the score is held at 0 and `wdOk` is 0. A pulse that ends during that time is ignored.
- R7: While `wdOk` is 1, both bounds of the window are one clock later, so the window becomes LO_BOUND+1 to HI_BOUND+1.
- R8: `enableOut` is equal to `wdOk` at all times.
- R9: A pulse that stays high past HI_BOUND+1 clocks saturates the width counter. The pulse is judged bad when it ends, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog time-base clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Trigger pulse from the supervised controller (asynchronous) |
| oscErr | input | 1 | Oscillator-failure indication, active high |
| wdOk | output | 1 | OK latch, 1 = no fault |
| enableOut | output | 1 | Enable that follows the OK latch |

## Verification
The bench builds the block with LO_BOUND=6, HI_BOUND=10 and MISS_LIMIT=40. With these values every window edge, the shifted edge used under OK and the missing-trigger timeout can be reached in a few dozen cycles. Random pulse widths from just below the lower bound to just above the shifted upper bound therefore reach every score state many times. Directed sequences cover the hysteresis edges, a pulse that saturates the width counter, the timeout, and a pulse that ends while the oscillator error is active.

// File: rtl/pww_pkg.sv
package pww_pkg;
  typedef struct packed {
    logic startPulse;
    logic inPulse;
    logic endPulse;
    logic missHit;
  } pwwStrobes_t;
endpackage

// File: rtl/pww_control.sv
module pww_control
  import pww_pkg::*;
#(
  parameter int MISS_LIMIT = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigIn,
  output pwwStrobes_t strobes
);
  localparam int MW = $clog2(MISS_LIMIT);

  logic [1:0]    syncQ;
  logic          trigPrev;
  logic [MW-1:0] missCnt;
  logic          trigLevel, riseSeen, fallSeen, missNow;

  assign trigLevel = syncQ[1];
  assign riseSeen  = trigLevel & ~trigPrev;
  assign fallSeen  = ~trigLevel & trigPrev;
  assign missNow   = ~riseSeen && (missCnt == MW'(MISS_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
      missCnt  <= '0;
    end else begin
      syncQ    <= {syncQ[0], trigIn};
      trigPrev <= trigLevel;
      if (riseSeen || missNow) missCnt <= '0;
      else                     missCnt <= missCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.startPulse = riseSeen;
    strobes.inPulse    = trigLevel & trigPrev;
    strobes.endPulse   = fallSeen;
    strobes.missHit    = missNow;
  end
endmodule

// File: rtl/pww_datapath.sv
module pww_datapath
  import pww_pkg::*;
#(
  parameter int LO_BOUND = 80,
  parameter int HI_BOUND = 120
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscErr,
  input  pwwStrobes_t strobes,
  output logic [1:0]  scoreVal,
  output logic        okFlag
);
  localparam int WCAP = HI_BOUND + 2;
  localparam int WW   = $clog2(WCAP + 1) + 1;

  logic [WW-1:0] widthCnt;
  logic [WW-1:0] loEdge, hiEdge;
  logic          pulseGood;
  logic [1:0]    scoreNext;
  logic          okNext;

  // saturating width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 widthCnt <= '0;
    else if (strobes.startPulse) widthCnt <= WW'(1);
    else if (strobes.inPulse && widthCnt != WW'(WCAP))
                               widthCnt <= widthCnt + 1'b1;
  end

  // window shifted by one clock while OK is set
  assign loEdge    = WW'(LO_BOUND) + WW'(okFlag);
  assign hiEdge    = WW'(HI_BOUND) + WW'(okFlag);
  assign pulseGood = (widthCnt >= loEdge) && (widthCnt <= hiEdge);

  always_comb begin
    scoreNext = scoreVal;
    okNext    = okFlag;
    if (oscErr || strobes.missHit) begin
      scoreNext = 2'd0;
      okNext    = 1'b0;
    end else if (strobes.endPulse) begin
      if (pulseGood) begin
        if (scoreVal != 2'd3) scoreNext = scoreVal + 2'd1;
      end else begin
        if (scoreVal != 2'd0) scoreNext = scoreVal - 2'd1;
      end
      if (scoreNext == 2'd3) okNext = 1'b1;
      else if (scoreNext == 2'd0) okNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scoreVal <= 2'd0;
      okFlag   <= 1'b0;
    end else begin
      scoreVal <= scoreNext;
      okFlag   <= okNext;
    end
  end
endmodule

// File: rtl/pulse_window_wd.sv
module pulse_window_wd
  import pww_pkg::*;
#(
  parameter int LO_BOUND   = 80,
  parameter int HI_BOUND   = 120,
  parameter int MISS_LIMIT = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  input  logic oscErr,
  output logic wdOk,
  output logic enableOut
);
  pwwStrobes_t strobes;
  logic [1:0]  scoreVal;

  pww_control #(.MISS_LIMIT(MISS_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .strobes(strobes)
  );

  pww_datapath #(.LO_BOUND(LO_BOUND), .HI_BOUND(HI_BOUND)) uData (
    .clk(clk), .rstN(rstN), .oscErr(oscErr), .strobes(strobes),
    .scoreVal(scoreVal), .okFlag(wdOk)
  );

  assign enableOut = wdOk;
endmodule

// File: rtl/pww_checker.sv
module pww_checker
  import pww_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        oscErr,
  input logic        wdOk,
  input logic        enableOut,
  input logic [1:0]  scoreVal,
  input pwwStrobes_t strobes
);
  a_r3_ok_at_three: assert property (@(posedge clk) disable iff (!rstN)
    scoreVal == 2'd3 |-> wdOk);

  a_r3_fault_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    scoreVal == 2'd0 |-> !wdOk);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!oscErr && !strobes.missHit) |=>
      ({1'b0, scoreVal} <= {1'b0, $past(scoreVal)} + 3'd1) &&
      ({1'b0, scoreVal} + 3'd1 >= {1'b0, $past(scoreVal)}));

  a_r1_hold_without_end: assert property (@(posedge clk) disable iff (!rstN)
    (!oscErr && !strobes.missHit && !strobes.endPulse) |=>
      ($stable(scoreVal) && $stable(wdOk)));

  a_r5_timeout_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.missHit |=> (scoreVal == 2'd0 && !wdOk));

  a_r6_osc_clears: assert property (@(posedge clk) disable iff (!rstN)
    oscErr |=> (scoreVal == 2'd0 && !wdOk));

  a_r8_enable_follows: assert property (@(posedge clk) disable iff (!rstN)
    enableOut == wdOk);
endmodule

bind pulse_window_wd pww_checker uChk (
  .clk(clk), .rstN(rstN), .oscErr(oscErr), .wdOk(wdOk),
  .enableOut(enableOut), .scoreVal(scoreVal), .strobes(strobes)
);

// File: tb/pulse_window_wd_test.sv
module pulse_window_wd_test;
  localparam int LO   = 6;
  localparam int HI   = 10;
  localparam int MISS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic oscErr = 1'b0;
  logic wdOk, enableOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int mScore = 0;
  bit mOk = 1'b0;

  always #5 clk = ~clk;

  pulse_window_wd #(.LO_BOUND(LO), .HI_BOUND(HI), .MISS_LIMIT(MISS)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .oscErr(oscErr),
    .wdOk(wdOk), .enableOut(enableOut)
  );

  function automatic bit isGood(int w, bit ok);
    return (w >= LO + int'(ok)) && (w <= HI + int'(ok));
  endfunction

  task automatic modelPulse(int w);
    if (oscErr) begin
      mScore = 0; mOk = 1'b0;
    end else begin
      if (isGood(w, mOk)) begin if (mScore < 3) mScore++; end
      else begin if (mScore > 0) mScore--; end
      if (mScore == 3) mOk = 1'b1;
      else if (mScore == 0) mOk = 1'b0;
    end
  endtask

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkOk(string tag);
    check(wdOk, mOk, tag);
    check(enableOut, wdOk, "R8 enable follows ok");
  endtask

  task automatic pulse(int w, int gap, string tag);
    @(negedge clk) trigIn = 1'b1;
    repeat (w) @(negedge clk);
    trigIn = 1'b0;
    modelPulse(w);
    repeat (gap) @(negedge clk);
    checkOk(tag);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(wdOk, 1'b0, "R4 ok low in reset");
    check(enableOut, 1'b0, "R4 enable low in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wdOk, 1'b0, "R4 ok low after reset");

    // climb 0->3, R2 R3
    pulse(8, 6, "R2 first good");
    pulse(8, 6, "R3 score2 fault holds");
    pulse(8, 6, "R3 score3 sets ok");
    // descend with OK set: LO is bad under shift (R7)
    pulse(LO, 6, "R7 lo edge bad when ok");
    pulse(HI + 1, 6, "R7 shifted hi good when ok");
    pulse(LO - 1, 6, "R2 bad decrement");
    pulse(LO - 1, 6, "R3 score1 nofault holds");
    pulse(LO - 1, 6, "R3 zero clears ok");
    pulse(LO - 1, 6, "R2 saturates at zero");
    // fault state window edges (R1)
    pulse(HI + 1, 6, "R1 hi+1 bad when fault");
    pulse(LO, 6, "R1 lo edge good when fault");
    pulse(HI, 6, "R1 hi edge good when fault");
    pulse(LO, 6, "R3 reach three");
    pulse(LO + 1, 6, "R2 saturates at three");
    // long saturating pulse (R9)
    pulse(30, 6, "R9 long pulse bad");
    pulse(8, 6, "R2 back to three");
    // gap below limit keeps state (R5)
    pulse(8, 25, "R5 short gap no effect");
    // timeout (R5)
    repeat (MISS + 10) @(negedge clk);
    mScore = 0; mOk = 1'b0;
    checkOk("R5 timeout clears");
    pulse(8, 6, "R5 rebuild 1");
    pulse(8, 6, "R5 rebuild 2");
    pulse(8, 6, "R5 rebuild 3 sets ok");
    // oscillator error (R6)
    @(negedge clk) oscErr = 1'b1;
    repeat (3) @(negedge clk);
    mScore = 0; mOk = 1'b0;
    checkOk("R6 osc error clears");
    pulse(8, 6, "R6 pulse ignored during error");
    @(negedge clk) oscErr = 1'b0;
    pulse(8, 6, "R6 after release 1");
    pulse(8, 6, "R6 after release 2 still fault");
    pulse(8, 6, "R6 after release 3 ok");
    // random mix (R1 R2 R3 R7)
    for (int i = 0; i < 300; i++) begin
      int w;
      int g;
      w = LO - 2 + int'($urandom_range(0, HI - LO + 5));
      g = 5 + int'($urandom_range(0, 10));
      pulse(w, g, "R1 random pulse");
    end
    done = 1'b1;
    finishRun();
  end
endmodule